// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block receives asynchronous serial frames of one start bit, eight data bits sent least significant bit first, and one stop bit. The line is first passed through a synchronizer. It is then looked at once per pulse of a tick enable that runs at sixteen times the bit rate. Each bit period is split into sixteen receive-time slots, numbered RT1 to RT16.

A 1-to-0 transition seen between two ticks marks RT1 of a possible start bit. The start is confirmed only if at most one of the RT3, RT5 and RT7 samples is high. Otherwise the receiver drops the attempt and searches again. Every later bit is decided by a majority of its RT8, RT9 and RT10 samples, and any disagreement among samples marks the frame as noisy. A stop bit whose majority is low marks a framing error.

When the stop bit's RT16 has been sampled, the byte and the two flags for that frame are presented together with a one-cycle valid strobe. They are held until the next frame completes. Baud-rate generation lives outside the block and reaches it only through the tick input.

Top module: `os_uart_rx`

## Requirements
- R1: After reset, rx_valid, rx_noise, rx_frame_err and rx_data are all 0, and the line is assumed idle-high.
- R2: A high-to-low change between consecutive tick samples starts a start-bit check. The start is accepted when the RT3/RT5/RT7 samples hold at most one 1 (patterns 000, 001, 010, 100), and a frame is then received.
- R3: When two or more of the RT3/RT5/RT7 samples are 1, the attempt is abandoned with no strobe and no flag. The receiver goes back to searching, and the next well-formed frame is received normally.
- R4: An accepted start with exactly one 1 among RT3/RT5/RT7 sets rx_noise for that frame.
- R5: A 1 in any of the start bit's RT8/RT9/RT10 samples sets rx_noise, but the frame is still received as valid.
- R6: Each of the 8 data bits takes the majority of its RT8/RT9/RT10 samples. The first data bit after the start becomes rx_data[0].
- R7: A data bit whose three voting samples are not all equal sets rx_noise, while the majority value is still kept.
- R8: A stop-bit majority of 0 sets rx_frame_err. A majority of 1 leaves it clear.
- R9: A stop bit whose three voting samples disagree sets rx_noise.
- R10: Samples outside the voting slots (any slot other than RT3/RT5/RT7 and RT8 to RT10 of the start bit, or other than RT8 to RT10 of the other bits) have no effect on data or flags.
- R11: rx_valid is a one-cycle pulse in the cycle after the stop bit's RT16 tick. rx_data and the flags change only with it, and the flags describe only that frame (they are restarted when a start is accepted).
- R12: A new start bit that follows a stop bit directly, with no idle slot in between, is detected and received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Sampling enable, one pulse per sixteenth of a bit |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe: a frame has completed |
| rx_noise | output | 1 | Noise was seen in the last frame |
| rx_frame_err | output | 1 | The stop bit of the last frame was low |

## Verification
A slot counter that is off by one moves the voting window. This shows at the ports within a single frame: a glitch placed on RT4 or RT11 raises rx_noise, or a glitch on RT8 fails to raise it. A sequencer that stays busy after a rejected start, or that misses the edge at the end of a stop bit, shows up as a missing strobe for the next frame. A shift in the wrong direction shows as a bit-reversed byte on the first asymmetric pattern.

// File: rtl/os_uart_rx_pkg.sv
package os_uart_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   localparam int RT_START_A = 3;
   localparam int RT_START_B = 5;
   localparam int RT_START_C = 7;

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= RESET_VAL;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 (
   input  logic [2:0] smp,
   output logic       maj,
   output logic       mixed,
   output logic       few_ones,
   output logic       any_one
);

   always_comb begin
      maj      = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
      mixed    = (smp != 3'b000) && (smp != 3'b111);
      few_ones = ~maj;
      any_one  = |smp;
   end

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
   import os_uart_rx_pkg::*;
#(
   parameter int DATA_BITS  = 8,
   parameter int OVERSAMPLE = 16,
   localparam int RTW = $clog2(OVERSAMPLE + 1),
   localparam int BCW = $clog2(DATA_BITS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 line_s,
   output logic [2:0]           vote_in,
   input  logic                 vote_maj,
   input  logic                 vote_mixed,
   input  logic                 vote_few_ones,
   input  logic                 vote_any_one,
   output logic [DATA_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 noise_o,
   output logic                 ferr_o,
   output logic [RTW-1:0]       rt_o,
   output logic                 busy_o
);

   localparam int RT_MID = OVERSAMPLE / 2 + 1;
   localparam logic [RTW-1:0] RT_VA  = RTW'(RT_START_A);
   localparam logic [RTW-1:0] RT_VB  = RTW'(RT_START_B);
   localparam logic [RTW-1:0] RT_VC  = RTW'(RT_START_C);
   localparam logic [RTW-1:0] RT_S1  = RTW'(RT_MID - 1);
   localparam logic [RTW-1:0] RT_S2  = RTW'(RT_MID);
   localparam logic [RTW-1:0] RT_S3  = RTW'(RT_MID + 1);
   localparam logic [RTW-1:0] RT_END = RTW'(OVERSAMPLE);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_BITS - 1);

   rx_state_e             state_q;
   logic [RTW-1:0]        rt_q;
   logic [BCW-1:0]        bit_q;
   logic                  prev_q;
   logic [1:0]            smp_q;
   logic [DATA_BITS-1:0]  shift_q;
   logic                  nz_acc_q;
   logic                  fe_acc_q;
   logic [DATA_BITS-1:0]  data_q;
   logic                  valid_q;
   logic                  noise_q;
   logic                  ferr_q;

   logic fall_seen;
   logic at_first, at_second, at_decide;

   assign vote_in   = {line_s, smp_q[1], smp_q[0]};
   assign fall_seen = prev_q & ~line_s;

   always_comb begin
      at_first  = 1'b0;
      at_second = 1'b0;
      at_decide = 1'b0;
      if (state_q == RX_START || state_q == RX_DATA || state_q == RX_STOP) begin
         at_first  = (rt_q == RT_S1);
         at_second = (rt_q == RT_S2);
         at_decide = (rt_q == RT_S3);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= RX_IDLE;
         rt_q     <= '0;
         bit_q    <= '0;
         prev_q   <= 1'b1;
         smp_q    <= '0;
         shift_q  <= '0;
         nz_acc_q <= 1'b0;
         fe_acc_q <= 1'b0;
         data_q   <= '0;
         valid_q  <= 1'b0;
         noise_q  <= 1'b0;
         ferr_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (tick) begin
            prev_q <= line_s;
            if (at_first)  smp_q[0] <= line_s;
            if (at_second) smp_q[1] <= line_s;
            unique case (state_q)
               RX_IDLE: begin
                  if (fall_seen) begin
                     state_q <= RX_START;
                     rt_q    <= RTW'(2);
                  end
               end
               RX_START: begin
                  rt_q <= rt_q + RTW'(1);
                  if (rt_q == RT_VA) smp_q[0] <= line_s;
                  if (rt_q == RT_VB) smp_q[1] <= line_s;
                  if (rt_q == RT_VC) begin
                     if (vote_few_ones) begin
                        nz_acc_q <= vote_any_one;
                        fe_acc_q <= 1'b0;
                     end else begin
                        state_q <= RX_IDLE;
                        rt_q    <= '0;
                     end
                  end
                  if (at_decide && vote_any_one) nz_acc_q <= 1'b1;
                  if (rt_q == RT_END) begin
                     state_q <= RX_DATA;
                     rt_q    <= RTW'(1);
                     bit_q   <= '0;
                  end
               end
               RX_DATA: begin
                  rt_q <= rt_q + RTW'(1);
                  if (at_decide) begin
                     shift_q <= {vote_maj, shift_q[DATA_BITS-1:1]};
                     if (vote_mixed) nz_acc_q <= 1'b1;
                  end
                  if (rt_q == RT_END) begin
                     rt_q <= RTW'(1);
                     if (bit_q == LAST_BIT) state_q <= RX_STOP;
                     else                   bit_q   <= bit_q + BCW'(1);
                  end
               end
               RX_STOP: begin
                  rt_q <= rt_q + RTW'(1);
                  if (at_decide) begin
                     fe_acc_q <= ~vote_maj;
                     if (vote_mixed) nz_acc_q <= 1'b1;
                  end
                  if (rt_q == RT_END) begin
                     state_q <= RX_IDLE;
                     rt_q    <= '0;
                     valid_q <= 1'b1;
                     data_q  <= shift_q;
                     noise_q <= nz_acc_q;
                     ferr_q  <= fe_acc_q;
                  end
               end
               default: state_q <= RX_IDLE;
            endcase
         end
      end
   end

   assign data_o  = data_q;
   assign valid_o = valid_q;
   assign noise_o = noise_q;
   assign ferr_o  = ferr_q;
   assign rt_o    = rt_q;
   assign busy_o  = (state_q != RX_IDLE);

endmodule

// File: rtl/os_uart_rx.sv
module os_uart_rx #(
   parameter int DATA_BITS   = 8,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2,
   localparam int RTW = $clog2(OVERSAMPLE + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_16x,
   input  logic                 rxd,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   output logic                 rx_noise,
   output logic                 rx_frame_err
);

   generate
      if (OVERSAMPLE != 16) begin : g_bad_os
         $error("os_uart_rx: OVERSAMPLE must be 16 for the fixed voting slots");
      end
      if (DATA_BITS < 1) begin : g_bad_db
         $error("os_uart_rx: DATA_BITS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("os_uart_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic           line_s;
   logic [2:0]     vote_in;
   logic           vote_maj, vote_mixed, vote_few_ones, vote_any_one;
   logic [RTW-1:0] rt_cnt;
   logic           busy;

   rx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rxd),
      .d_out (line_s)
   );

   rx_vote3 u_vote (
      .smp      (vote_in),
      .maj      (vote_maj),
      .mixed    (vote_mixed),
      .few_ones (vote_few_ones),
      .any_one  (vote_any_one)
   );

   rx_frame_ctrl #(
      .DATA_BITS  (DATA_BITS),
      .OVERSAMPLE (OVERSAMPLE)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick_16x),
      .line_s        (line_s),
      .vote_in       (vote_in),
      .vote_maj      (vote_maj),
      .vote_mixed    (vote_mixed),
      .vote_few_ones (vote_few_ones),
      .vote_any_one  (vote_any_one),
      .data_o        (rx_data),
      .valid_o       (rx_valid),
      .noise_o       (rx_noise),
      .ferr_o        (rx_frame_err),
      .rt_o          (rt_cnt),
      .busy_o        (busy)
   );

endmodule

// File: rtl/os_uart_rx_chk.sv
module os_uart_rx_chk #(
   parameter int DATA_BITS  = 8,
   parameter int OVERSAMPLE = 16,
   localparam int RTW = $clog2(OVERSAMPLE + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tick_16x,
   input logic [DATA_BITS-1:0] rx_data,
   input logic                 rx_valid,
   input logic                 rx_noise,
   input logic                 rx_frame_err,
   input logic [RTW-1:0]       rt_cnt,
   input logic                 busy
);

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid); // R11

   AST_VALID_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(tick_16x)); // R11

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> ($stable(rx_noise) && $stable(rx_frame_err))); // R11

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |-> $stable(rx_data)); // R6

   AST_RT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (rt_cnt >= RTW'(1) && rt_cnt <= RTW'(OVERSAMPLE))); // R2

   AST_RT_STILL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick_16x) |-> $stable(rt_cnt)); // R2

endmodule

bind os_uart_rx os_uart_rx_chk #(
   .DATA_BITS  (DATA_BITS),
   .OVERSAMPLE (OVERSAMPLE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_16x     (tick_16x),
   .rx_data      (rx_data),
   .rx_valid     (rx_valid),
   .rx_noise     (rx_noise),
   .rx_frame_err (rx_frame_err),
   .rt_cnt       (rt_cnt),
   .busy         (busy)
);

// File: tb/os_uart_rx_tb_top.sv
`timescale 1ns/1ps
module os_uart_rx_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_16x;
   logic       rxd = 1'b1;
   logic [7:0] rx_data;
   logic       rx_valid, rx_noise, rx_frame_err;
   logic [1:0] tcnt = 2'd0;

   int n_cmp = 0;
   int n_bad = 0;
   int cap_cnt = 0;
   int dbl_pulse = 0;
   logic [7:0] cap_data [0:63];
   logic       cap_nz   [0:63];
   logic       cap_fe   [0:63];
   logic       last_valid = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) tcnt <= tcnt + 2'd1;
   assign tick_16x = (tcnt == 2'd3);

   os_uart_rx dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_16x     (tick_16x),
      .rxd          (rxd),
      .rx_data      (rx_data),
      .rx_valid     (rx_valid),
      .rx_noise     (rx_noise),
      .rx_frame_err (rx_frame_err)
   );

   always @(negedge clk) begin
      if (rx_valid && cap_cnt < 64) begin
         cap_data[cap_cnt] = rx_data;
         cap_nz[cap_cnt]   = rx_noise;
         cap_fe[cap_cnt]   = rx_frame_err;
         cap_cnt = cap_cnt + 1;
      end
      if (rx_valid && last_valid) dbl_pulse = dbl_pulse + 1;
      last_valid = rx_valid;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic slot(input logic v);
      rxd = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) slot(1'b1);
   endtask

   // bit index 0 = start, 1..8 = data, 9 = stop; rt 1..16; -1 = no flip
   task automatic send_frame(input logic [7:0] d, input int fb1, input int fr1,
                             input int fb2, input int fr2, input logic stop_v,
                             input int idle_after);
      for (int b = 0; b < 10; b++) begin
         logic base;
         base = (b == 0) ? 1'b0 : (b == 9) ? stop_v : d[b-1];
         for (int r = 1; r <= 16; r++) begin
            logic v;
            v = base;
            if ((b == fb1 && r == fr1) || (b == fb2 && r == fr2)) v = ~v;
            slot(v);
         end
      end
      idle(idle_after);
   endtask

   task automatic expect_frame(input string tag, input int base_cnt,
                               input logic [7:0] d, input logic nz, input logic fe);
      chk({tag, " frame count"}, cap_cnt, base_cnt + 1);
      if (cap_cnt > base_cnt) begin
         chk({tag, " data"},  cap_data[base_cnt], d);
         chk({tag, " noise"}, cap_nz[base_cnt], nz);
         chk({tag, " ferr"},  cap_fe[base_cnt], fe);
      end
   endtask

   task automatic t_reset();
      chk("R1 valid", rx_valid, 0);
      chk("R1 noise", rx_noise, 0);
      chk("R1 ferr", rx_frame_err, 0);
      chk("R1 data", rx_data, 0);
   endtask

   task automatic t_clean();
      logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
      for (int i = 0; i < 4; i++) begin
         int c0 = cap_cnt;
         send_frame(pats[i], -1, 0, -1, 0, 1'b1, 4);
         expect_frame("R2 R6 clean", c0, pats[i], 1'b0, 1'b0);
      end
   endtask

   task automatic t_start_noise();
      int pos [3] = '{3, 5, 7};
      for (int i = 0; i < 3; i++) begin
         int c0 = cap_cnt;
         send_frame(8'h5A, 0, pos[i], -1, 0, 1'b1, 4);
         expect_frame("R4 start single 1", c0, 8'h5A, 1'b1, 1'b0);
      end
   endtask

   task automatic t_start_late();
      for (int r = 8; r <= 10; r++) begin
         int c0 = cap_cnt;
         send_frame(8'h81, 0, r, -1, 0, 1'b1, 4);
         expect_frame("R5 start late 1", c0, 8'h81, 1'b1, 1'b0);
      end
   endtask

   task automatic t_reject();
      int c0 = cap_cnt;
      // low for RT1..RT16 except RT3 and RT5 high: votes 1,1,0 -> rejected
      for (int r = 1; r <= 16; r++) slot((r == 3 || r == 5) ? 1'b1 : 1'b0);
      idle(20);
      chk("R3 no frame after two-ones start", cap_cnt, c0);
      send_frame(8'hC3, -1, 0, -1, 0, 1'b1, 4);
      expect_frame("R3 restart after reject", c0, 8'hC3, 1'b0, 1'b0);
      c0 = cap_cnt;
      // short low pulse: only RT1 and RT2 low -> votes 1,1,1 -> rejected
      slot(1'b0); slot(1'b0);
      idle(30);
      chk("R3 no frame after glitch start", cap_cnt, c0);
      send_frame(8'h69, -1, 0, -1, 0, 1'b1, 4);
      expect_frame("R3 restart after glitch", c0, 8'h69, 1'b0, 1'b0);
   endtask

   task automatic t_data_noise();
      int c0 = cap_cnt;
      send_frame(8'h0F, 4, 8, -1, 0, 1'b1, 4);
      expect_frame("R7 data RT8 glitch", c0, 8'h0F, 1'b1, 1'b0);
      c0 = cap_cnt;
      send_frame(8'h0F, 8, 10, -1, 0, 1'b1, 4);
      expect_frame("R7 data RT10 glitch", c0, 8'h0F, 1'b1, 1'b0);
      c0 = cap_cnt;
      send_frame(8'h0F, 1, 9, -1, 0, 1'b1, 4);
      expect_frame("R7 R6 data RT9 glitch", c0, 8'h0F, 1'b1, 1'b0);
   endtask

   task automatic t_stop();
      int c0 = cap_cnt;
      send_frame(8'h96, -1, 0, -1, 0, 1'b0, 4);
      expect_frame("R8 stop low", c0, 8'h96, 1'b0, 1'b1);
      c0 = cap_cnt;
      send_frame(8'h96, 9, 9, -1, 0, 1'b1, 4);
      expect_frame("R9 stop high glitch", c0, 8'h96, 1'b1, 1'b0);
      c0 = cap_cnt;
      send_frame(8'h96, 9, 8, -1, 0, 1'b0, 4);
      expect_frame("R8 R9 stop low glitch", c0, 8'h96, 1'b1, 1'b1);
   endtask

   task automatic t_ignored();
      int c0 = cap_cnt;
      send_frame(8'h4B, 0, 4, 3, 13, 1'b1, 4);
      expect_frame("R10 start RT4 data RT13", c0, 8'h4B, 1'b0, 1'b0);
      c0 = cap_cnt;
      send_frame(8'h4B, 5, 7, 9, 11, 1'b1, 4);
      expect_frame("R10 data RT7 stop RT11", c0, 8'h4B, 1'b0, 1'b0);
   endtask

   task automatic t_flag_clear();
      int c0 = cap_cnt;
      send_frame(8'h11, 9, 8, -1, 0, 1'b0, 4);
      send_frame(8'h22, -1, 0, -1, 0, 1'b1, 4);
      chk("R11 two frames", cap_cnt, c0 + 2);
      if (cap_cnt >= c0 + 2) begin
         chk("R11 noise cleared", cap_nz[c0 + 1], 0);
         chk("R11 ferr cleared", cap_fe[c0 + 1], 0);
      end
      chk("R11 outputs held noise", rx_noise, 0);
      chk("R11 single-cycle strobe", dbl_pulse, 0);
   endtask

   task automatic t_back_to_back();
      int c0 = cap_cnt;
      send_frame(8'hE7, -1, 0, -1, 0, 1'b1, 0);
      send_frame(8'h18, -1, 0, -1, 0, 1'b1, 0);
      send_frame(8'h55, -1, 0, -1, 0, 1'b1, 4);
      chk("R12 back-to-back count", cap_cnt, c0 + 3);
      if (cap_cnt >= c0 + 3) begin
         chk("R12 first", cap_data[c0], 8'hE7);
         chk("R12 second", cap_data[c0 + 1], 8'h18);
         chk("R12 third", cap_data[c0 + 2], 8'h55);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      idle(4);
      t_clean();
      t_start_noise();
      t_start_late();
      t_reject();
      t_data_noise();
      t_stop();
      t_ignored();
      t_flag_clear();
      t_back_to_back();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule